// File: doc/BRIEF.md
# Multithreaded Thread Select Unit

This block sits at the front of a multithreaded core. Each cycle it decides which hardware thread may issue and presents that thread's program counter. The block keeps one PC and one sleep flag for each thread. Each thread also reports a short stall for the current cycle. The pipeline datapath and the register files are replicated for each thread and are not part of this block.

Two switching policies share one selector. In fine-grain mode the issuing thread rotates every cycle in round-robin order, and threads that cannot issue are skipped. In coarse-grain mode one thread keeps ownership of the pipeline. It gives up ownership only when it suffers a long-latency stall, such as a second-level cache miss. A short stall only holds issue back for that cycle. A long stall puts its thread to sleep until a matching wake pulse arrives.

The selection is combinational from the current inputs and the registered state, so the `sel_*` outputs describe the current cycle. A valid selection is an issue: at the next clock edge the chosen thread's PC advances by 4, unless a redirect loads a new target. The mode input is only taken into account while the unit is in its idle state.

Controller states:
- `ST_IDLE`: entered at reset, and again whenever a cycle yields no selection. The exception is a coarse-mode owner that is only short-stalled.
- `ST_FINE`: rotating policy.
- `ST_COARSE`: ownership policy.

Transitions:
- IDLE→FINE or IDLE→COARSE on the first cycle that selects a thread, chosen by `mode_coarse_i`.
- FINE→IDLE when no thread is ready.
- COARSE→IDLE when the owner is asleep or long-stalled and no other thread is ready.
- FINE never goes to COARSE directly, and COARSE never goes to FINE directly.

Top module: `thread_select_unit`

## Requirements
- R1: After reset every thread is awake. Thread t's PC is 0x1000 + 0x100·t. The unit is idle, and its first search starts at thread 0.
- R2: In fine-grain mode the selection moves each cycle to the next ready thread after the last selected one, in increasing thread order with wrap-around. If only one thread is ready, that thread is selected again.
- R3: A thread is ready when it is not asleep and its bit in `stall_i` and `long_stall_i` is 0. A thread that is not ready is never selected, and in fine-grain mode it is skipped.
- R4: In coarse-grain mode the owner thread is selected on every cycle in which it is ready, whatever the other threads do.
- R5: In coarse-grain mode, a `stall_i` on the owner (without a long stall) drives `sel_valid_o` low for that cycle. Ownership is kept, and the owner resumes when the stall drops.
- R6: In coarse-grain mode, a `long_stall_i` on the owner, or the owner being asleep, hands ownership in the same cycle to the next ready thread after the owner in round-robin order.
- R7: A `long_stall_i` bit puts its thread to sleep from the next cycle. A `wake_i` bit wakes it from the next cycle. If both arrive for one thread in the same cycle, the sleep wins.
- R8: When no thread is ready, `sel_valid_o` is 0.
- R9: On every valid selection the selected thread's PC increases by 4 at the next clock edge. The PCs of threads that are not selected and not redirected do not change.
- R10: A redirect (`redir_valid_i` with `redir_tid_i`) loads `redir_pc_i` into that thread's PC at the next edge. This takes priority over the increment from a simultaneous issue.
- R11: `mode_coarse_i` (0 = fine-grain, 1 = coarse-grain) is sampled only in `ST_IDLE`. Changing it while a policy is running does not change the policy.
- R12: `sel_pc_o` equals the current PC of the thread on `sel_tid_o` whenever `sel_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_coarse_i | input | 1 | Policy request: 0 fine-grain, 1 coarse-grain (used only when idle) |
| stall_i | input | N_THREADS | Short stall for each thread, this cycle only |
| long_stall_i | input | N_THREADS | Long-latency stall for each thread; puts the thread to sleep |
| wake_i | input | N_THREADS | Wake pulse for each thread |
| redir_valid_i | input | 1 | Redirect request |
| redir_tid_i | input | TID_W | Thread that the redirect targets |
| redir_pc_i | input | PC_W | Redirect target address |
| sel_valid_o | output | 1 | A thread issues this cycle |
| sel_tid_o | output | TID_W | Selected thread |
| sel_pc_o | output | PC_W | PC of the selected thread |

## Verification
A corrupted round-robin pointer or owner shows up on `sel_tid_o` in the very cycle that follows it, because the next search starts from that register. A corrupted state register shows up as a policy that never switches, or switches on a short stall, within one or two cycles of the next stall event. A wrong sleep flag either issues a long-stalled thread on the next cycle or leaves a woken thread unselected. A wrong PC register is visible on `sel_pc_o` the next time that thread is selected, which is at most N_THREADS cycles later in fine-grain mode with all threads ready.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FINE   = 2'd1,
        ST_COARSE = 2'd2
    } tsu_state_e;

endpackage

// File: rtl/tsu_rr_pick.sv
module tsu_rr_pick #(
    parameter int N_THREADS = 4,
    parameter int TID_W     = 2
) (
    input  logic [N_THREADS-1:0] req_i,
    input  logic [TID_W-1:0]     base_i,
    output logic                 found_o,
    output logic [TID_W-1:0]     idx_o
);

    // Search starts at base+1 and ends at base itself.
    always_comb begin
        found_o = 1'b0;
        idx_o   = base_i;
        for (int k = 1; k <= N_THREADS; k++) begin
            if (!found_o && req_i[(int'(base_i) + k) % N_THREADS]) begin
                found_o = 1'b1;
                idx_o   = TID_W'((int'(base_i) + k) % N_THREADS);
            end
        end
    end

endmodule

// File: rtl/tsu_sleep_tracker.sv
module tsu_sleep_tracker #(
    parameter int N_THREADS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_THREADS-1:0] sleep_set_i,
    input  logic [N_THREADS-1:0] sleep_clr_i,
    output logic [N_THREADS-1:0] asleep_o
);

    logic [N_THREADS-1:0] asleep_q;

    // A set beats a clear for the same thread.
    always_ff @(posedge clk) begin
        if (!rst_n) asleep_q <= '0;
        else        asleep_q <= (asleep_q & ~sleep_clr_i) | sleep_set_i;
    end

    assign asleep_o = asleep_q;

    for (genvar t = 0; t < N_THREADS; t++) begin : g_chk
        p_sleep_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            sleep_set_i[t] |=> asleep_o[t]);
        p_wake_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sleep_clr_i[t] && !sleep_set_i[t]) |=> !asleep_o[t]);
    end

endmodule

// File: rtl/tsu_pc_bank.sv
module tsu_pc_bank #(
    parameter int             N_THREADS   = 4,
    parameter int             PC_W        = 32,
    parameter logic [PC_W-1:0] BOOT_PC     = 'h1000,
    parameter logic [PC_W-1:0] BOOT_STRIDE = 'h100,
    parameter logic [PC_W-1:0] PC_STEP     = 'd4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_THREADS-1:0] issue_en_i,
    input  logic [N_THREADS-1:0] redir_en_i,
    input  logic [PC_W-1:0]      redir_pc_i,
    output logic [PC_W-1:0]      pc_o [N_THREADS]
);

    for (genvar t = 0; t < N_THREADS; t++) begin : g_pc
        localparam logic [PC_W-1:0] RST_PC = BOOT_PC + BOOT_STRIDE * PC_W'(t);
        logic [PC_W-1:0] pc_q;

        always_ff @(posedge clk) begin
            if (!rst_n)              pc_q <= RST_PC;
            else if (redir_en_i[t])  pc_q <= redir_pc_i;
            else if (issue_en_i[t])  pc_q <= pc_q + PC_STEP;
        end

        assign pc_o[t] = pc_q;

        p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_en_i[t] && !redir_en_i[t]) |=> pc_o[t] == $past(pc_o[t]) + PC_STEP);
        p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!issue_en_i[t] && !redir_en_i[t]) |=> $stable(pc_o[t]));
        p_pc_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
            redir_en_i[t] |=> pc_o[t] == $past(redir_pc_i));
    end

endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit
    import tsu_pkg::*;
#(
    parameter int              N_THREADS   = 4,
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] BOOT_PC     = 'h1000,
    parameter logic [PC_W-1:0] BOOT_STRIDE = 'h100,
    parameter logic [PC_W-1:0] PC_STEP     = 'd4,
    localparam int             TID_W       = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_coarse_i,
    input  logic [N_THREADS-1:0] stall_i,
    input  logic [N_THREADS-1:0] long_stall_i,
    input  logic [N_THREADS-1:0] wake_i,
    input  logic                 redir_valid_i,
    input  logic [TID_W-1:0]     redir_tid_i,
    input  logic [PC_W-1:0]      redir_pc_i,
    output logic                 sel_valid_o,
    output logic [TID_W-1:0]     sel_tid_o,
    output logic [PC_W-1:0]      sel_pc_o
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(N_THREADS - 1);

    tsu_state_e           st_q, st_d;
    logic [TID_W-1:0]     last_q, last_d;   // last issuer (fine) / owner (coarse)
    logic [N_THREADS-1:0] asleep;
    logic [N_THREADS-1:0] ready;
    logic                 pick_found;
    logic [TID_W-1:0]     pick_idx;
    logic                 owner_live;
    logic [N_THREADS-1:0] issue_vec, redir_vec;
    logic [PC_W-1:0]      pc_arr [N_THREADS];

    assign ready      = ~asleep & ~stall_i & ~long_stall_i;
    assign owner_live = !asleep[last_q] && !long_stall_i[last_q];

    tsu_sleep_tracker #(.N_THREADS(N_THREADS)) u_sleep (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_set_i (long_stall_i),
        .sleep_clr_i (wake_i),
        .asleep_o    (asleep)
    );

    tsu_rr_pick #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_pick (
        .req_i   (ready),
        .base_i  (last_q),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            last_q <= LAST_TID;
        end else begin
            st_q   <= st_d;
            last_q <= last_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (pick_found) st_d = mode_coarse_i ? ST_COARSE : ST_FINE;
            end
            ST_FINE: begin
                if (!pick_found) st_d = ST_IDLE;
            end
            ST_COARSE: begin
                if (!owner_live && !pick_found) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sel_valid_o = 1'b0;
        sel_tid_o   = last_q;
        unique case (st_q)
            ST_IDLE, ST_FINE: begin
                sel_valid_o = pick_found;
                sel_tid_o   = pick_idx;
            end
            ST_COARSE: begin
                if (owner_live) begin
                    sel_valid_o = !stall_i[last_q];
                    sel_tid_o   = last_q;
                end else begin
                    sel_valid_o = pick_found;
                    sel_tid_o   = pick_idx;
                end
            end
            default: begin
                sel_valid_o = 1'b0;
                sel_tid_o   = last_q;
            end
        endcase
        last_d = sel_valid_o ? sel_tid_o : last_q;
    end

    for (genvar t = 0; t < N_THREADS; t++) begin : g_vec
        assign issue_vec[t] = sel_valid_o && (sel_tid_o == TID_W'(t));
        assign redir_vec[t] = redir_valid_i && (redir_tid_i == TID_W'(t));
    end

    tsu_pc_bank #(
        .N_THREADS   (N_THREADS),
        .PC_W        (PC_W),
        .BOOT_PC     (BOOT_PC),
        .BOOT_STRIDE (BOOT_STRIDE),
        .PC_STEP     (PC_STEP)
    ) u_pcs (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_en_i (issue_vec),
        .redir_en_i (redir_vec),
        .redir_pc_i (redir_pc_i),
        .pc_o       (pc_arr)
    );

    assign sel_pc_o = pc_arr[sel_tid_o];

    p_issue_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (!stall_i[sel_tid_o] && !asleep[sel_tid_o] && !long_stall_i[sel_tid_o]));
    p_none_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready == '0) |-> !sel_valid_o);
    p_fine_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FINE && sel_valid_o && $past(sel_valid_o) && $countones(ready) > 1)
            |-> sel_tid_o != $past(sel_tid_o));
    p_coarse_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COARSE && sel_valid_o && sel_tid_o != last_q)
            |-> (asleep[last_q] || long_stall_i[last_q]));
    p_fine_no_coarse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FINE) |=> (st_q != ST_COARSE));
    p_coarse_no_fine_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COARSE) |=> (st_q != ST_FINE));

endmodule

// File: tb/thread_select_unit_tb.sv
module thread_select_unit_tb_top;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_coarse = 1'b0;
    logic [3:0]  stall = '0, lstall = '0, wake = '0;
    logic        rvalid = 1'b0;
    logic [1:0]  rtid = '0;
    logic [31:0] rpc = '0;
    logic        sel_valid;
    logic [1:0]  sel_tid;
    logic [31:0] sel_pc;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    typedef struct {
        bit          ev;
        int          etid;
        logic [31:0] epc;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] pcm [N];

    always #4 clk = ~clk;

    thread_select_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_coarse_i (mode_coarse),
        .stall_i       (stall),
        .long_stall_i  (lstall),
        .wake_i        (wake),
        .redir_valid_i (rvalid),
        .redir_tid_i   (rtid),
        .redir_pc_i    (rpc),
        .sel_valid_o   (sel_valid),
        .sel_tid_o     (sel_tid),
        .sel_pc_o      (sel_pc)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Drive one cycle of stimulus and queue what the ports must show.
    task automatic step(input logic [3:0] st, input logic [3:0] ls, input logic [3:0] wk,
                        input bit rd, input int rt, input logic [31:0] rp,
                        input bit ev, input int etid, input string tag);
        exp_t e;
        stall = st; lstall = ls; wake = wk;
        rvalid = rd; rtid = 2'(rt); rpc = rp;
        e.ev = ev; e.etid = etid; e.epc = pcm[etid]; e.tag = tag;
        sb_q.push_back(e);
        if (ev) pcm[etid] = pcm[etid] + 32'd4;   // R9
        if (rd) pcm[rt] = rp;                    // R10 priority
        @(negedge clk);
    endtask

    // Monitor: compare mid-phase, away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (sel_valid !== e.ev ||
                    (e.ev && (int'(sel_tid) != e.etid || sel_pc !== e.epc))) begin
                    n_bad++;
                    $display("FAIL %s R12: got valid=%0b tid=%0d pc=%h, expected valid=%0b tid=%0d pc=%h",
                             e.tag, sel_valid, sel_tid, sel_pc, e.ev, e.etid, e.epc);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles, expected under 5000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        for (int t = 0; t < N; t++) pcm[t] = 32'h1000 + 32'h100 * t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Fine-grain rotation
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 0, "R1 reset pc / first pick");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 1, "R2 rotate");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 2, "R2 rotate");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 3, "R2 rotate");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 0, "R2 wrap R9");
        step(4'h2, 4'h0, 4'h0, 0, 0, 0, 1, 2, "R3 skip stalled");
        step(4'h9, 4'h0, 4'h0, 0, 0, 0, 1, 1, "R3 skip two");
        mode_coarse = 1'b1;
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 2, "R11 mode ignored while running");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 3, "R11 still fine");
        step(4'hF, 4'h0, 4'h0, 0, 0, 0, 0, 0, "R8 none ready");
        // Coarse-grain (mode taken in idle)
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 0, "R11 coarse taken in idle");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 0, "R4 hold owner");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 0, "R4 hold owner");
        step(4'h1, 4'h0, 4'h0, 0, 0, 0, 0, 0, "R5 short stall no issue");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 0, "R5 owner resumes");
        step(4'h0, 4'h1, 4'h0, 0, 0, 0, 1, 1, "R6 long stall switch");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 1, "R4 new owner held");
        step(4'h0, 4'h2, 4'h1, 0, 0, 0, 1, 2, "R7 wake not yet effective R6");
        step(4'h0, 4'h4, 4'h0, 0, 0, 0, 1, 3, "R6 switch");
        step(4'h0, 4'h8, 4'h0, 0, 0, 0, 1, 0, "R7 woken thread selected");
        step(4'h0, 4'h1, 4'h1, 0, 0, 0, 0, 0, "R8 all asleep");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, "R7 sleep beats wake");
        mode_coarse = 1'b0;
        step(4'h0, 4'h0, 4'h2, 0, 0, 0, 0, 0, "R7 wake next cycle");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 1, "R7 woken R11 fine");
        step(4'h0, 4'h0, 4'hD, 0, 0, 0, 1, 1, "R2 single ready repeats");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 2, "R2 rotate");
        // Redirects
        step(4'h0, 4'h0, 4'h0, 1, 3, 32'h4000, 1, 3, "R10 issue+redirect");
        step(4'h0, 4'h0, 4'h0, 1, 2, 32'h2200, 1, 0, "R10 redirect other");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 1, "R9 step");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 2, "R10 target seen");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 3, "R10 priority over step");
        step(4'h0, 4'h0, 4'h0, 0, 0, 0, 1, 0, "R9 step after redirect");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule